// File: doc/BRIEF.md
# Multi-Channel Conversion Scan Sequencer

This block sits between a register port and one shared analog-to-digital conversion engine. Software fills one control word with a mode, a channel field, a trigger choice and an interrupt enable. A scan then starts in one of two ways: software writes the go bit, or a rising edge arrives on the hardware trigger line that the control word selects. The sequencer hands the engine one channel at a time through a start/done handshake. It files each returned sample in that channel's own result register. When the last channel is done it raises a sticky end flag, and an interrupt if that is enabled.

In multi-channel mode the channel field is a bit mask, and every set channel is converted exactly once, lowest number first. In single mode the low bits of the field name one channel, and only that channel is converted. A scan never repeats by itself: each scan needs a fresh start.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control word (address 0) and every result register read 0. `irq` and `convStart` are low.
- R2: Writing a control word with bit 0 set starts a scan when the sequencer is idle. Bit 0 reads 1 from the next cycle until the last selected channel completes, and reads 0 after that.
- R3: Control bits 5:4 pick the hardware trigger. Value 0 means none, and value k picks `trigIn[k-1]`. A rising edge on the picked line starts a scan when idle. Edges on any other line have no effect.
- R4: With control bit 3 = 1 (multi-channel mode), bits 13:8 form a channel mask. Each set channel is converted exactly once, in ascending channel order.
- R5: With control bit 3 = 0 (single mode), bits 10:8 give a channel index. Only that channel is converted, and an index of 6 or 7 selects no channel.
- R6: Result register n (address 1+n) takes the value of `convResult` from the cycle in which `convDone` ends channel n's conversion. Registers of unselected channels keep their values.
- R7: `convStart` is a one-cycle pulse carrying the channel on `convChan`. No new pulse is issued until `convDone` has answered the previous one.
- R8: Control bit 1 (end flag) is set when a scan finishes. Only a control write with bit 1 = 0 clears it, and writing 1 to it has no effect.
- R9: `irq` equals the end flag ANDed with control bit 2 (interrupt enable).
- R10: A start that selects no channel sets the end flag by the next cycle and issues no conversion.
- R11: A software start or trigger edge that arrives while a scan is running is ignored. The running scan converts each selected channel only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address: 0 control, 1..6 results |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data (combinational) |
| trigIn | input | 3 | Hardware trigger lines |
| convStart | output | 1 | One-cycle conversion start to the engine |
| convChan | output | 3 | Channel for the conversion being started |
| convDone | input | 1 | Engine completion pulse |
| convResult | input | 16 | Engine result, valid with convDone |
| irq | output | 1 | Scan-end interrupt request |

## Verification
Every one of the 64 masks in multi-channel mode is run, which separates a correct ascending walk from skipped, repeated or reordered channels. Single mode is tried with all eight index values, which separates real channels from the two out-of-range codes that must act like an empty selection. Each trigger setting is driven first with edges on the unselected lines and then on the selected one, which shows that the select field really routes the trigger. Repeated starts during a running scan, set-only writes to the end flag, and alternating interrupt enables separate ignored stimuli from ones that take effect.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2
  } seqState_e;

  typedef struct packed {
    logic finishSet;
    logic resultWe;
  } seqStrobe_t;

  localparam int BIT_GO    = 0;
  localparam int BIT_END   = 1;
  localparam int BIT_IE    = 2;
  localparam int BIT_MULTI = 3;
  localparam int TRG_LO    = 4;
  localparam int CH_LO     = 8;

endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CHW    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [NUM_CH-1:0] scanMask,
  input  logic              convDone,
  output logic              convStart,
  output logic [CHW-1:0]    convChan,
  output seqStrobe_t        strobe,
  output logic [CHW-1:0]    resultIdx,
  output logic              busy
);

  seqState_e         state;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] pendingAfter;
  logic [CHW-1:0]    curChan;
  logic [CHW-1:0]    lowIdx;
  logic              firstIssue;

  always_comb begin
    lowIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pending[i]) lowIdx = CHW'(i);
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      pendingAfter[i] = pending[i] && (curChan != CHW'(i));
    end
  end

  always_comb begin
    convStart        = (state == SEQ_ISSUE);
    convChan         = lowIdx;
    resultIdx        = curChan;
    strobe.resultWe  = (state == SEQ_WAIT) && convDone;
    strobe.finishSet = ((state == SEQ_IDLE) && startReq && (scanMask == '0)) ||
                       ((state == SEQ_WAIT) && convDone && (pendingAfter == '0));
    busy             = (state != SEQ_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= SEQ_IDLE;
      pending    <= '0;
      curChan    <= '0;
      firstIssue <= 1'b0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (startReq && (scanMask != '0)) begin
            pending    <= scanMask;
            firstIssue <= 1'b1;
            state      <= SEQ_ISSUE;
          end
        end
        SEQ_ISSUE: begin
          curChan    <= lowIdx;
          firstIssue <= 1'b0;
          state      <= SEQ_WAIT;
        end
        SEQ_WAIT: begin
          if (convDone) begin
            pending <= pendingAfter;
            state   <= (pendingAfter == '0) ? SEQ_IDLE : SEQ_ISSUE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R7: start is a single-cycle pulse
  a_r7_start_single: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R4: later conversions of one scan use strictly higher channels
  a_r4_ascending: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && !firstIssue) |-> (convChan > curChan));

  // R11: a start request during a scan leaves the pending set alone
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && !convDone) |=> $stable(pending));

  // R10: an empty selection never leaves idle
  a_r10_empty_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq && (scanMask == '0)) |=> !busy);

endmodule

// File: rtl/adc_scan_dpath.sv
module adc_scan_dpath
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int CHW      = 3,
  parameter int RES_W    = 16,
  parameter int NUM_TRIG = 3,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  seqStrobe_t        strobe,
  input  logic [CHW-1:0]    resultIdx,
  input  logic [RES_W-1:0]  resultData,
  input  logic              busy,
  output logic              startReq,
  output logic [NUM_CH-1:0] scanMask,
  output logic              irq
);

  logic              cfgIe;
  logic              cfgMulti;
  logic [1:0]        cfgTrig;
  logic [NUM_CH-1:0] cfgChan;
  logic              endFlag;
  logic [NUM_TRIG-1:0] trigPrev;
  logic [NUM_TRIG-1:0] trigRise;
  logic              hwTrig;
  logic              ctrlWr;
  logic              nextMulti;
  logic [NUM_CH-1:0] nextChan;
  logic [RES_W-1:0]  resBank [NUM_CH];
  logic [DATA_W-1:0] ctrlWord;

  assign ctrlWr    = busWrEn && (busAddr == '0);
  assign nextMulti = ctrlWr ? busWrData[BIT_MULTI] : cfgMulti;
  assign nextChan  = ctrlWr ? busWrData[CH_LO +: NUM_CH] : cfgChan;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      scanMask[i] = nextMulti ? nextChan[i] : (nextChan[CHW-1:0] == CHW'(i));
    end
  end

  assign trigRise = trigIn & ~trigPrev;

  always_comb begin
    hwTrig = 1'b0;
    for (int k = 0; k < NUM_TRIG; k++) begin
      if ((cfgTrig == 2'(k + 1)) && trigRise[k]) hwTrig = 1'b1;
    end
  end

  assign startReq = (ctrlWr && busWrData[BIT_GO]) || hwTrig;
  assign irq      = endFlag && cfgIe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgIe    <= 1'b0;
      cfgMulti <= 1'b0;
      cfgTrig  <= '0;
      cfgChan  <= '0;
      endFlag  <= 1'b0;
      trigPrev <= '0;
    end else begin
      trigPrev <= trigIn;
      if (ctrlWr) begin
        cfgIe    <= busWrData[BIT_IE];
        cfgMulti <= busWrData[BIT_MULTI];
        cfgTrig  <= busWrData[TRG_LO +: 2];
        cfgChan  <= busWrData[CH_LO +: NUM_CH];
      end
      if (strobe.finishSet)                     endFlag <= 1'b1;
      else if (ctrlWr && !busWrData[BIT_END])   endFlag <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_res
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resBank[g] <= '0;
      end else if (strobe.resultWe && (resultIdx == CHW'(g))) begin
        resBank[g] <= resultData;
      end
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[BIT_GO]             = busy;
    ctrlWord[BIT_END]            = endFlag;
    ctrlWord[BIT_IE]             = cfgIe;
    ctrlWord[BIT_MULTI]          = cfgMulti;
    ctrlWord[TRG_LO +: 2]        = cfgTrig;
    ctrlWord[CH_LO +: NUM_CH]    = cfgChan;
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == '0) busRdData = ctrlWord;
    for (int i = 0; i < NUM_CH; i++) begin
      if (busAddr == ADDR_W'(i + 1)) busRdData = DATA_W'(resBank[i]);
    end
  end

  // R8: the end flag survives everything except a clearing write
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (endFlag && !(ctrlWr && !busWrData[BIT_END])) |=> endFlag);

  // R6: results are filed only during a running scan
  a_r6_write_in_scan: assert property (@(posedge clk) disable iff (!rstN)
    strobe.resultWe |-> busy);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int RES_W    = 16,
  parameter int NUM_TRIG = 3,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_TRIG-1:0] trigIn,
  output logic                convStart,
  output logic [$clog2(NUM_CH)-1:0] convChan,
  input  logic                convDone,
  input  logic [RES_W-1:0]    convResult,
  output logic                irq
);

  localparam int CHW = $clog2(NUM_CH);

  seqStrobe_t        strobe;
  logic [CHW-1:0]    resultIdx;
  logic              busy;
  logic              startReq;
  logic [NUM_CH-1:0] scanMask;

  adc_scan_ctrl #(.NUM_CH(NUM_CH), .CHW(CHW)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .scanMask(scanMask),
    .convDone(convDone), .convStart(convStart), .convChan(convChan),
    .strobe(strobe), .resultIdx(resultIdx), .busy(busy)
  );

  adc_scan_dpath #(.NUM_CH(NUM_CH), .CHW(CHW), .RES_W(RES_W), .NUM_TRIG(NUM_TRIG),
                   .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .trigIn(trigIn),
    .strobe(strobe), .resultIdx(resultIdx), .resultData(convResult),
    .busy(busy), .startReq(startReq), .scanMask(scanMask), .irq(irq)
  );

endmodule

// File: tb/adc_scan_seq_tb_top.sv
`timescale 1ns/1ps
module adc_scan_seq_tb_top;

  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [2:0]  trigIn = '0;
  logic        convStart;
  logic [2:0]  convChan;
  logic        convDone = 1'b0;
  logic [15:0] convResult = '0;
  logic        irq;

  always #2 clk = ~clk;

  adc_scan_seq dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .trigIn(trigIn),
    .convStart(convStart), .convChan(convChan), .convDone(convDone),
    .convResult(convResult), .irq(irq)
  );

  int nChecks = 0;
  int nFail   = 0;
  int logChan [32];
  int logN    = 0;
  int overlapErr = 0;
  logic [15:0] expRes [NCH];
  logic [7:0]  tag = 8'h00;
  int cyc = 0;

  // engine model: latency depends on channel
  bit   mBusy = 0;
  int   mCnt  = 0;
  logic [2:0] mChan = '0;
  always @(negedge clk) begin
    convDone = 1'b0;
    if (mBusy) begin
      if (mCnt == 0) begin
        convDone   = 1'b1;
        convResult = {tag, 5'b0, mChan};
        mBusy      = 0;
      end else begin
        mCnt = mCnt - 1;
      end
    end
    if (rstN && convStart) begin
      if (mBusy) overlapErr++;
      mBusy = 1;
      mChan = convChan;
      mCnt  = 1 + (int'(convChan) % 3);
      if (logN < 32) logChan[logN] = int'(convChan);
      logN++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  function automatic logic [31:0] mk(input bit go, input bit endB, input bit ie,
                                     input bit multi, input int trg, input int chan);
    return 32'(go) | (32'(endB) << 1) | (32'(ie) << 2) | (32'(multi) << 3) |
           (32'(trg) << 4) | (32'(chan) << 8);
  endfunction

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      rd(3'd0, v);
      if (!v[0]) return;
      @(negedge clk);
    end
    chk("R2 scan ends", 32'd1, 32'd0);
  endtask

  // checks order, results, flag, irq; then clears the flag
  task automatic verifyScan(input string req, input int mask, input logic [31:0] cfg);
    logic [31:0] v;
    int k = 0;
    bit ie = cfg[2];
    chk({req, " R4 conversion count"}, 32'(logN), 32'($countones(mask[5:0])));
    for (int c = 0; c < NCH; c++) begin
      if (mask[c]) begin
        if (k < logN) chk({req, " R4 ascending order"}, 32'(logChan[k]), 32'(c));
        k++;
        expRes[c] = {tag, 5'b0, 3'(c)};
      end
    end
    for (int c = 0; c < NCH; c++) begin
      rd(3'(c + 1), v);
      chk({req, " R6 result register"}, v, 32'(expRes[c]));
    end
    rd(3'd0, v);
    chk({req, " R8 end flag set"}, 32'(v[1]), 32'd1);
    chk({req, " R9 irq"}, 32'(irq), 32'(ie));
    wr(3'd0, cfg & ~32'h3);
    rd(3'd0, v);
    chk({req, " R8 flag cleared by 0"}, 32'(v[1]), 32'd0);
    chk({req, " R9 irq low"}, 32'(irq), 32'd0);
  endtask

  task automatic pulseTrig(input int line);
    @(negedge clk);
    trigIn[line] = 1'b1;
    @(negedge clk);
    trigIn[line] = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] cfg;
    for (int c = 0; c < NCH; c++) expRes[c] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v);
    chk("R1 control word", v, 32'd0);
    for (int c = 0; c < NCH; c++) begin
      rd(3'(c + 1), v);
      chk("R1 result reg", v, 32'd0);
    end
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 convStart", 32'(convStart), 32'd0);

    // R8 writing 1 to the end flag does nothing
    wr(3'd0, mk(0, 1, 1, 1, 0, 0));
    rd(3'd0, v);
    chk("R8 write 1 no effect", 32'(v[1]), 32'd0);
    chk("R9 irq stays low", 32'(irq), 32'd0);

    // R4 R6 R10 multi-channel sweep over every mask
    for (int m = 0; m < 64; m++) begin
      tag = tag + 8'd1;
      logN = 0;
      cfg = mk(0, 0, m[0], 1, 0, m);
      wr(3'd0, cfg | 32'h1);
      if (m == 0) begin
        rd(3'd0, v);
        chk("R10 empty mask flag at once", 32'(v[1:0]), 32'h2);
      end
      waitIdle();
      verifyScan("multi", m, cfg);
    end

    // R5 single mode over every index code
    for (int idx = 0; idx < 8; idx++) begin
      tag = tag + 8'd1;
      logN = 0;
      cfg = mk(0, 0, 1, 0, 0, idx);
      wr(3'd0, cfg | 32'h1);
      if (idx >= NCH) begin
        rd(3'd0, v);
        chk("R5 R10 out-of-range index empty", 32'(v[1:0]), 32'h2);
      end
      waitIdle();
      verifyScan("R5 single", (idx < NCH) ? (1 << idx) : 0, cfg);
    end

    // R3 trigger selection
    for (int sel = 0; sel < 4; sel++) begin
      tag = tag + 8'd1;
      logN = 0;
      cfg = mk(0, 0, 0, 1, sel, 6'b101101);
      wr(3'd0, cfg);
      for (int ln = 0; ln < 3; ln++) begin
        if (ln + 1 != sel) pulseTrig(ln);
      end
      repeat (12) @(negedge clk);
      rd(3'd0, v);
      chk("R3 unselected trigger ignored count", 32'(logN), 32'd0);
      chk("R3 unselected trigger ignored flag", 32'(v[1:0]), 32'd0);
      if (sel > 0) begin
        pulseTrig(sel - 1);
        waitIdle();
        verifyScan("R3 selected trigger", 6'b101101, cfg);
      end
    end

    // R2 R11 restart attempts during a scan are ignored
    tag = tag + 8'd1;
    logN = 0;
    cfg = mk(0, 0, 1, 1, 1, 6'b111111);
    wr(3'd0, cfg | 32'h1);
    rd(3'd0, v);
    chk("R2 go bit reads 1 while busy", 32'(v[0]), 32'd1);
    wr(3'd0, cfg | 32'h1);
    pulseTrig(0);
    wr(3'd0, cfg | 32'h1);
    waitIdle();
    rd(3'd0, v);
    chk("R2 go bit cleared at end", 32'(v[0]), 32'd0);
    verifyScan("R11 busy restart", 6'b111111, cfg);

    chk("R7 no overlapping starts", 32'(overlapErr), 32'd0);

    summary();
    $finish;
  end

endmodule